// File: doc/BRIEF.md
# Short-Cycle Successive-Approximation Sequencer

This block is the digital controller behind a 12-bit successive-approximation converter. When a conversion is started, it walks the result from the most significant bit downward. It presents one trial word per clock to the DAC and keeps or drops each trial bit according to a single comparator bit. The analog parts are outside the block. The comparator is seen only as that one input bit, which is 1 when the sampled input is at or above the current trial word.

A length-select input is sampled on the clock edge that accepts a start. If it was high, the sequencer stops after eight decisions. The result then carries the eight decided bits on top, bit 3 forced to 1 and bits 2..0 cleared, which places the value in the middle of the unresolved span. If it was low, all twelve bits are resolved. A busy flag covers the whole conversion. The completed result stays in a register until the next conversion finishes.

Top module: `sar_seq`

## Requirements
- R1: A synchronous active-high reset clears the result register to 0x000, drops busy to 0, and makes the trial output 0x000.
- R2: A conversion starts when the read/convert input falls (high on one rising clock edge, low on the next) while enable is 1 and the active-low select is 0. Busy reads 1 after that second edge.
- R3: A falling read/convert edge seen while enable is 0 or select is 1 starts nothing, and the result register keeps its value.
- R4: The length-select input is sampled only on the start edge. Changing it during a conversion changes neither the length nor the result.
- R5: With length-select sampled as 0, busy stays high for exactly 12 clock cycles, and the result equals the 12-bit code the comparator steers toward.
- R6: With length-select sampled as 1, busy stays high for exactly 8 cycles. Result bits 11..4 hold the decisions, bit 3 is 1 and bits 2..0 are 0.
- R7: Bits are decided MSB first, one per cycle. In the k-th busy cycle (k = 0 first), the trial word holds the kept bits above position 11-k, plus a 1 at position 11-k. The first trial word is 0x800.
- R8: A falling read/convert edge during a conversion is ignored. The conversion runs to its normal length, and no second conversion follows it.
- R9: Holding read/convert low after a conversion does not start another one. A new start needs a new falling edge.
- R10: While idle, the trial output shows the result register, and the result stays unchanged until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable, must be 1 to accept a start |
| sel_n_i | input | 1 | Active-low select, must be 0 to accept a start |
| rdconv_i | input | 1 | Read/convert line; a falling edge requests a conversion |
| len_sel_i | input | 1 | Length select: 1 short (8 bits), 0 full (12 bits), sampled at start |
| cmp_i | input | 1 | Comparator decision for the current trial word |
| result_o | output | 12 | Last completed conversion result |
| busy_o | output | 1 | High while a conversion runs |
| trial_o | output | 12 | Trial word for the DAC |

## Verification
A corrupted bit index or kept-bit register shows on the trial output in the very next cycle, because the trial word is checked against its expected value in every busy cycle. A wrong length latch or stop condition shows as a busy pulse of the wrong width, and as a result whose low nibble is not the required pattern, when busy falls. A faulty start detector shows within one cycle of a falling read/convert edge, either as busy that fails to rise or as a busy that rises again after a conversion ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
    parameter int unsigned SAR_WIDTH      = 12;
    parameter int unsigned SAR_SHORT_BITS = 8;

    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } sar_len_e;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sel_n_i,
    input  logic rdconv_i,
    input  logic busy_i,
    output logic start_o
);
    typedef struct packed {
        logic rdconv;
    } det_state_t;

    det_state_t det_d, det_q;

    always_comb begin
        det_d        = det_q;
        det_d.rdconv = rdconv_i;
        start_o      = en_i && !sel_n_i && det_q.rdconv && !rdconv_i && !busy_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // A single falling edge produces a single start pulse
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // No start is raised while a conversion is running
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !start_o);
endmodule

// File: rtl/sar_trial_gen.sv
module sar_trial_gen #(
    parameter int unsigned WIDTH = sar_pkg::SAR_WIDTH,
    localparam int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic             busy_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [WIDTH-1:0] kept_i,
    input  logic [WIDTH-1:0] result_i,
    output logic [WIDTH-1:0] trial_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign trial_o[b] = busy_i ? (kept_i[b] || (idx_i == IDX_W'(b))) : result_i[b];
    end
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH      = SAR_WIDTH,
    parameter int unsigned SHORT_BITS = SAR_SHORT_BITS,
    localparam int unsigned IDX_W     = $clog2(WIDTH),
    localparam int unsigned TAIL_POS  = WIDTH - SHORT_BITS - 1,
    localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(WIDTH - SHORT_BITS),
    localparam logic [IDX_W-1:0] FULL_LAST  = '0,
    localparam logic [WIDTH-1:0] TAIL_MASK  = WIDTH'(1) << TAIL_POS,
    localparam logic [WIDTH-1:0] LOW_MASK   = TAIL_MASK - WIDTH'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             len_sel_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [WIDTH-1:0] kept_o,
    output logic [WIDTH-1:0] result_o
);
    typedef struct packed {
        logic             busy;
        sar_len_e         len;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] kept;
        logic [WIDTH-1:0] result;
    } core_state_t;

    core_state_t core_d, core_q;
    logic [IDX_W-1:0] last_idx;
    logic [WIDTH-1:0] kept_next;

    always_comb begin
        core_d    = core_q;
        last_idx  = (core_q.len == LEN_SHORT) ? SHORT_LAST : FULL_LAST;
        kept_next = core_q.kept;
        kept_next[core_q.idx] = cmp_i;

        if (!core_q.busy) begin
            if (start_i) begin
                core_d.busy = 1'b1;
                core_d.len  = sar_len_e'(len_sel_i);
                core_d.idx  = IDX_W'(WIDTH - 1);
                core_d.kept = '0;
            end
        end else begin
            core_d.kept = kept_next;
            if (core_q.idx == last_idx) begin
                core_d.busy   = 1'b0;
                core_d.result = (core_q.len == LEN_SHORT) ? (kept_next | TAIL_MASK) : kept_next;
            end else begin
                core_d.idx = core_q.idx - IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy_o   = core_q.busy;
    assign idx_o    = core_q.idx;
    assign kept_o   = core_q.kept;
    assign result_o = core_q.result;

    // An accepted start makes the core busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !core_q.busy) |=> core_q.busy);

    // Length is frozen for the whole conversion
    p_len_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (core_q.busy && $past(core_q.busy)) |-> $stable(core_q.len));

    // Bit position moves down by one each busy cycle
    p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
        (core_q.busy && core_d.busy) |=> (core_q.idx == $past(core_q.idx) - IDX_W'(1)));

    // Conversion ends at the position chosen by the latched length
    p_stop_point_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(core_q.busy) |-> ($past(core_q.idx) == (($past(core_q.len) == LEN_SHORT) ? SHORT_LAST : FULL_LAST)));

    // A short result carries the fixed tail pattern
    p_short_tail_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_q.busy) && core_q.len == LEN_SHORT) |->
            (core_q.result[TAIL_POS] && ((core_q.result & LOW_MASK) == '0)));

    // Result only changes on the cycle a conversion completes
    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$fell(core_q.busy) |-> $stable(core_q.result));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH      = SAR_WIDTH,
    parameter int unsigned SHORT_BITS = SAR_SHORT_BITS,
    localparam int unsigned IDX_W     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             sel_n_i,
    input  logic             rdconv_i,
    input  logic             len_sel_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] result_o,
    output logic             busy_o,
    output logic [WIDTH-1:0] trial_o
);
    logic             start;
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] result;

    sar_start_detect i_start (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .sel_n_i  (sel_n_i),
        .rdconv_i (rdconv_i),
        .busy_i   (busy),
        .start_o  (start)
    );

    sar_core #(
        .WIDTH      (WIDTH),
        .SHORT_BITS (SHORT_BITS)
    ) i_core (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .len_sel_i (len_sel_i),
        .cmp_i     (cmp_i),
        .busy_o    (busy),
        .idx_o     (idx),
        .kept_o    (kept),
        .result_o  (result)
    );

    sar_trial_gen #(
        .WIDTH (WIDTH)
    ) i_trial (
        .busy_i   (busy),
        .idx_i    (idx),
        .kept_i   (kept),
        .result_i (result),
        .trial_o  (trial_o)
    );

    assign busy_o   = busy;
    assign result_o = result;

    // First trial word of every conversion is the MSB alone
    p_first_trial_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (trial_o == (WIDTH'(1) << (WIDTH - 1))));

    // Idle trial word mirrors the stored result
    p_idle_trial_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (trial_o == result_o));
endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b1;
    logic        sel_n_i = 1'b0;
    logic        rdconv_i = 1'b1;
    logic        len_sel_i = 1'b0;
    logic        cmp_i;
    logic [11:0] result_o;
    logic        busy_o;
    logic [11:0] trial_o;
    logic [11:0] vin = 12'h000;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    assign cmp_i = (vin >= trial_o);

    sar_seq i_sar_seq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .sel_n_i   (sel_n_i),
        .rdconv_i  (rdconv_i),
        .len_sel_i (len_sel_i),
        .cmp_i     (cmp_i),
        .result_o  (result_o),
        .busy_o    (busy_o),
        .trial_o   (trial_o)
    );

    // {analog code, length select, expected result}
    localparam logic [24:0] VEC [0:9] = '{
        {12'hA5C, 1'b0, 12'hA5C},
        {12'hA5C, 1'b1, 12'hA58},
        {12'hFFF, 1'b0, 12'hFFF},
        {12'hFFF, 1'b1, 12'hFF8},
        {12'h000, 1'b0, 12'h000},
        {12'h000, 1'b1, 12'h008},
        {12'h801, 1'b0, 12'h801},
        {12'h7FF, 1'b1, 12'h7F8},
        {12'h123, 1'b0, 12'h123},
        {12'h5A7, 1'b1, 12'h5A8}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // mode 0: plain; 1: flip length select mid-run; 2: extra falling edge mid-run
    task automatic run_conv(input logic [11:0] v, input logic lsel, input logic [11:0] exp,
                            input int mode, input string req);
        int k;
        int exp_len;
        logic [11:0] above;
        logic [11:0] exp_tr;
        exp_len = lsel ? 8 : 12;
        vin = v;
        @(negedge clk);
        len_sel_i = lsel;
        rdconv_i  = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
        k = 0;
        while (busy_o && k < 20) begin
            above  = (k == 0) ? 12'h000 : (v & ~((12'h001 << (12 - k)) - 12'h001));
            exp_tr = above | (12'h001 << (11 - k));
            chk(trial_o == exp_tr, "R7 trial word", 32'(trial_o), 32'(exp_tr));
            if (mode == 1 && k == 3) len_sel_i = ~lsel;
            if (mode == 2 && k == 2) rdconv_i = 1'b1;
            if (mode == 2 && k == 4) rdconv_i = 1'b0;
            k++;
            @(negedge clk);
        end
        chk(k == exp_len, {req, " busy length"}, 32'(k), 32'(exp_len));
        chk(result_o == exp, {req, " result"}, 32'(result_o), 32'(exp));
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, {req, " no restart"}, 32'(busy_o), 32'd0);
        rdconv_i  = 1'b1;
        len_sel_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(result_o == 12'h000, "R1 result after reset", 32'(result_o), 32'h0);
        chk(busy_o == 1'b0, "R1 busy after reset", 32'(busy_o), 32'd0);
        chk(trial_o == 12'h000, "R1 trial after reset", 32'(trial_o), 32'h0);

        // Table of conversions (R5 full, R6 short)
        for (int i = 0; i < 10; i++) begin
            run_conv(VEC[i][24:13], VEC[i][12], VEC[i][11:0], 0, VEC[i][12] ? "R6" : "R5");
        end

        // R10: idle trial mirrors result; result holds when input changes
        vin = 12'h3C3;
        repeat (5) @(negedge clk);
        chk(result_o == 12'h5A8, "R10 result held", 32'(result_o), 32'h5A8);
        chk(trial_o == 12'h5A8, "R10 idle trial", 32'(trial_o), 32'h5A8);

        // R3: enable low blocks start
        en_i = 1'b0;
        @(negedge clk);
        rdconv_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R3 enable low", 32'(busy_o), 32'd0);
        rdconv_i = 1'b1;
        en_i = 1'b1;
        // R3: select high blocks start
        sel_n_i = 1'b1;
        @(negedge clk);
        rdconv_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R3 select high", 32'(busy_o), 32'd0);
        chk(result_o == 12'h5A8, "R3 result kept", 32'(result_o), 32'h5A8);
        rdconv_i = 1'b1;
        sel_n_i = 1'b0;
        @(negedge clk);

        // R4: length select flipped mid-run has no effect
        run_conv(12'h9B6, 1'b1, 12'h9B8, 1, "R4 short flip");
        run_conv(12'h9B6, 1'b0, 12'h9B6, 1, "R4 full flip");

        // R8: extra falling edge during conversion ignored
        run_conv(12'h6D2, 1'b0, 12'h6D2, 2, "R8 extra edge");

        // R9: read/convert held low after a conversion does not restart
        vin = 12'h444;
        @(negedge clk);
        rdconv_i = 1'b0;
        repeat (14) @(negedge clk);
        chk(result_o == 12'h444, "R9 first conversion", 32'(result_o), 32'h444);
        repeat (20) @(negedge clk);
        chk(busy_o == 1'b0, "R9 held low idle", 32'(busy_o), 32'd0);
        rdconv_i = 1'b1;
        @(negedge clk);

        // R1: reset during a conversion
        vin = 12'hABC;
        rdconv_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b1, "R1 busy before reset", 32'(busy_o), 32'd1);
        do_reset();
        chk(busy_o == 1'b0, "R1 busy cleared mid-run", 32'(busy_o), 32'd0);
        chk(result_o == 12'h000, "R1 result cleared mid-run", 32'(result_o), 32'h0);
        rdconv_i = 1'b1;
        @(negedge clk);
        run_conv(12'hABC, 1'b0, 12'hABC, 0, "R5 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule